// File: doc/BRIEF.md
# Link Power State Event Controller

This block is the power-management sequencer of a serial-link endpoint. It watches the device power-state field that software programs, together with enable bits for the light and deep low-power link states. When the link enters or leaves the light idle state (L1), it drives a single-cycle event pulse. It also reacts to a turn-off message from the system. It announces entry into the deep power-down state (L2) with a single-cycle pulse and asks the transmit side to send an acknowledge message.

The acknowledge path can be set by configuration. With `ack_hold` low, the acknowledge request follows the turn-off message at once. With `ack_hold` high, the block stays pending after the L2-enter pulse until user logic answers on `user_ack`. The user logic uses that time to save whatever state it must keep before power is removed. No L1 entry starts while that handshake is pending.

All pins are plain control and status levels or strobes. There is no data stream and no back-pressure: every input is sampled on each rising clock edge, and every output is a registered pulse that is visible for the cycle after the edge that decided it.

Top module: `lpm_event_ctrl`

## Requirements
- R1: In the L0 state, if `pwr_state` is not D0 (encoding 2'b00), `l1_en` is 1 and no acknowledge is pending at a clock edge, then `l1_enter` is 1 for exactly the next cycle and the block is in L1.
- R2: When `pwr_state` equals 2'b00 or `l1_en` is 0, `l1_enter` stays 0.
- R3: In L1, if `sys_exit_req` or `wake_req` is 1 at a clock edge, then `l1_exit` is 1 for exactly the next cycle and the block returns to L0.
- R4: Exit requests while in L0 have no effect. A second `l1_enter` pulse never comes without an `l1_exit` pulse in between, even if the entry condition stays true.
- R5: A `turnoff_rx` strobe with `l2_en` = 1 and no acknowledge pending gives a one-cycle `l2_enter` pulse in the next cycle. With `l2_en` = 0 no `l2_enter` pulse is issued.
- R6: If `ack_hold` is 0 or `l2_en` is 0 when the turn-off strobe is taken, `ack_tx` pulses for one cycle in the next cycle, and `user_ack` is ignored.
- R7: If `ack_hold` is 1 and `l2_en` is 1, no `ack_tx` comes with the `l2_enter` pulse. The block stays pending, and `ack_tx` pulses in the cycle after the first edge at which `user_ack` is 1.
- R8: At most one `ack_tx` pulse is issued per accepted turn-off message. A `turnoff_rx` strobe while an acknowledge is pending is ignored (no `l2_enter`, no `ack_tx`).
- R9: A `user_ack` with no acknowledge pending has no effect on `ack_tx`.
- R10: While an acknowledge is pending (from the cycle showing `l2_enter` up to the cycle showing `ack_tx`), no L1 entry is decided.
- R11: Synchronous active-low reset returns the block to L0 with nothing pending and all four pulse outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_state | input | 2 | Programmed device power state, 2'b00 is D0 |
| l1_en | input | 1 | L1 support enable |
| l2_en | input | 1 | L2 support enable |
| ack_hold | input | 1 | 1: the acknowledge waits for `user_ack`; 0: the acknowledge is automatic |
| turnoff_rx | input | 1 | One-cycle strobe: turn-off message received |
| wake_req | input | 1 | User wake/PME request, leaves L1 |
| sys_exit_req | input | 1 | System-side request to leave L1 |
| user_ack | input | 1 | User acknowledge for a held turn-off |
| l1_enter | output | 1 | One-cycle pulse: L1 entry started |
| l1_exit | output | 1 | One-cycle pulse: L1 left, back to L0 |
| l2_enter | output | 1 | One-cycle pulse: L2 entry started |
| ack_tx | output | 1 | One-cycle pulse: send the acknowledge message |

## Verification
The assertions assume that `turnoff_rx` arrives as a strobe and that the configuration bits are stable while they are in use. They also assume that the pending state seen at the ports can be rebuilt from the `l2_enter` and `ack_tx` pulses alone. The stimulus keeps to this by changing all inputs only on falling edges and by raising `turnoff_rx` for one cycle at a time. It also sweeps every power-state code and every enable and mode combination from the idle state, and it returns the block to L0 with nothing pending before each new case.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic {
    LNK_L0 = 1'b0,
    LNK_L1 = 1'b1
  } lnk_state_t;

  typedef enum logic {
    TO_IDLE = 1'b0,
    TO_WAIT = 1'b1
  } to_state_t;

endpackage

// File: rtl/lpm_lowpow_detect.sv
module lpm_lowpow_detect #(
  parameter int              PS_W    = 2,
  parameter logic [PS_W-1:0] D0_CODE = '0
) (
  input  logic [PS_W-1:0] pwr_state,
  input  logic            l1_en,
  input  logic            ack_pending,
  output logic            l1_go
);
  // Any state other than fully-on requests the light idle state.
  logic not_d0;
  assign not_d0 = (pwr_state != D0_CODE);
  assign l1_go  = not_d0 && l1_en && !ack_pending;
endmodule

// File: rtl/lpm_l1_fsm.sv
module lpm_l1_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l1_go,
  input  logic sys_exit_req,
  input  logic wake_req,
  output logic l1_enter,
  output logic l1_exit
);
  lnk_state_t state_q;
  logic       enter_q;
  logic       exit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LNK_L0;
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
      unique case (state_q)
        LNK_L0: begin
          if (l1_go) begin
            state_q <= LNK_L1;
            enter_q <= 1'b1;
          end
        end
        LNK_L1: begin
          if (sys_exit_req || wake_req) begin
            state_q <= LNK_L0;
            exit_q  <= 1'b1;
          end
        end
        default: state_q <= LNK_L0;
      endcase
    end
  end

  assign l1_enter = enter_q;
  assign l1_exit  = exit_q;
endmodule

// File: rtl/lpm_l2_fsm.sv
module lpm_l2_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic turnoff_rx,
  input  logic l2_en,
  input  logic ack_hold,
  input  logic user_ack,
  output logic l2_enter,
  output logic ack_tx,
  output logic ack_pending
);
  to_state_t state_q;
  logic      l2_enter_q;
  logic      ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TO_IDLE;
      l2_enter_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      l2_enter_q <= 1'b0;
      ack_q      <= 1'b0;
      unique case (state_q)
        TO_IDLE: begin
          if (turnoff_rx) begin
            l2_enter_q <= l2_en;
            // The handshake is only offered when an entry pulse is given.
            if (l2_en && ack_hold) state_q <= TO_WAIT;
            else                   ack_q   <= 1'b1;
          end
        end
        TO_WAIT: begin
          if (user_ack) begin
            ack_q   <= 1'b1;
            state_q <= TO_IDLE;
          end
        end
        default: state_q <= TO_IDLE;
      endcase
    end
  end

  assign l2_enter    = l2_enter_q;
  assign ack_tx      = ack_q;
  assign ack_pending = (state_q == TO_WAIT);
endmodule

// File: rtl/lpm_event_ctrl.sv
module lpm_event_ctrl #(
  parameter int              PS_W    = 2,
  parameter logic [PS_W-1:0] D0_CODE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] pwr_state,
  input  logic            l1_en,
  input  logic            l2_en,
  input  logic            ack_hold,
  input  logic            turnoff_rx,
  input  logic            wake_req,
  input  logic            sys_exit_req,
  input  logic            user_ack,
  output logic            l1_enter,
  output logic            l1_exit,
  output logic            l2_enter,
  output logic            ack_tx
);
  logic ack_pending;
  logic l1_go;

  lpm_lowpow_detect #(
    .PS_W    (PS_W),
    .D0_CODE (D0_CODE)
  ) u_detect (
    .pwr_state   (pwr_state),
    .l1_en       (l1_en),
    .ack_pending (ack_pending),
    .l1_go       (l1_go)
  );

  lpm_l1_fsm u_l1 (
    .clk          (clk),
    .rst_n        (rst_n),
    .l1_go        (l1_go),
    .sys_exit_req (sys_exit_req),
    .wake_req     (wake_req),
    .l1_enter     (l1_enter),
    .l1_exit      (l1_exit)
  );

  lpm_l2_fsm u_l2 (
    .clk         (clk),
    .rst_n       (rst_n),
    .turnoff_rx  (turnoff_rx),
    .l2_en       (l2_en),
    .ack_hold    (ack_hold),
    .user_ack    (user_ack),
    .l2_enter    (l2_enter),
    .ack_tx      (ack_tx),
    .ack_pending (ack_pending)
  );
endmodule

// File: rtl/lpm_event_ctrl_chk.sv
module lpm_event_ctrl_chk #(
  parameter int              PS_W    = 2,
  parameter logic [PS_W-1:0] D0_CODE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PS_W-1:0] pwr_state,
  input logic            l1_en,
  input logic            l2_en,
  input logic            ack_hold,
  input logic            turnoff_rx,
  input logic            wake_req,
  input logic            sys_exit_req,
  input logic            user_ack,
  input logic            l1_enter,
  input logic            l1_exit,
  input logic            l2_enter,
  input logic            ack_tx
);
  // Shadow state rebuilt from the output pulses only.
  logic in_l1_q;
  logic pend_q;
  logic pend_now;

  assign pend_now = (pend_q || l2_enter) && !ack_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_l1_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      in_l1_q <= (in_l1_q || l1_enter) && !l1_exit;
      pend_q  <= pend_now;
    end
  end

  // R1
  l1_enter_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_enter |=> !l1_enter);

  // R1
  l1_enter_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_enter |-> $past((pwr_state != D0_CODE) && l1_en));

  // R3
  l1_exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_exit |-> $past(sys_exit_req || wake_req));

  // R4
  l1_enter_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_enter |-> !in_l1_q);

  // R4
  l1_exit_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_exit |-> in_l1_q);

  // R5
  l2_enter_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_enter |-> $past(turnoff_rx && l2_en));

  // R6
  auto_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turnoff_rx && !pend_now && (!ack_hold || !l2_en)) |=> ack_tx);

  // R7
  held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turnoff_rx && !pend_now && l2_en && ack_hold) |=> (l2_enter && !ack_tx));

  // R7
  user_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_now && user_ack) |=> ack_tx);

  // R8
  turnoff_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_now && turnoff_rx) |=> !l2_enter);

  // R9
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_now && !turnoff_rx) |=> !ack_tx);

  // R10
  l1_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_now |=> !l1_enter);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !(l1_enter || l1_exit || l2_enter || ack_tx));
endmodule

bind lpm_event_ctrl lpm_event_ctrl_chk #(
  .PS_W    (PS_W),
  .D0_CODE (D0_CODE)
) u_chk (.*);

// File: tb/tb_lpm_event_ctrl.sv
module tb_lpm_event_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pwr_state;
  logic       l1_en, l2_en, ack_hold, turnoff_rx, wake_req, sys_exit_req, user_ack;
  logic       l1_enter, l1_exit, l2_enter, ack_tx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_event_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .l1_en(l1_en),
    .l2_en(l2_en), .ack_hold(ack_hold), .turnoff_rx(turnoff_rx),
    .wake_req(wake_req), .sys_exit_req(sys_exit_req), .user_ack(user_ack),
    .l1_enter(l1_enter), .l1_exit(l1_exit), .l2_enter(l2_enter), .ack_tx(ack_tx)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; pwr_state = 2'b00; l1_en = 0; l2_en = 0; ack_hold = 0;
    turnoff_rx = 0; wake_req = 0; sys_exit_req = 0; user_ack = 0;
    repeat (3) tick();
    chk("R11", "l1_enter in reset", l1_enter, 1'b0);
    chk("R11", "l1_exit in reset", l1_exit, 1'b0);
    chk("R11", "l2_enter in reset", l2_enter, 1'b0);
    chk("R11", "ack_tx in reset", ack_tx, 1'b0);
    rst_n = 1;
    tick();

    // R1 R2 R3 R4: every power-state code against both enable levels.
    for (int ps = 0; ps < 4; ps++) begin
      for (int en = 0; en < 2; en++) begin
        logic exp_in;
        exp_in = (ps != 0) && (en == 1);
        pwr_state = 2'(ps); l1_en = 1'(en);
        tick();
        chk(exp_in ? "R1" : "R2", "l1_enter after condition", l1_enter, exp_in);
        tick();
        chk("R4", "no second l1_enter while held", l1_enter, 1'b0);
        pwr_state = 2'b00; l1_en = 0;
        if (ps[0]) wake_req = 1; else sys_exit_req = 1;
        tick();
        chk(exp_in ? "R3" : "R4", "l1_exit on exit request", l1_exit, exp_in);
        wake_req = 0; sys_exit_req = 0;
        tick();
        chk("R3", "l1_exit one cycle", l1_exit, 1'b0);
      end
    end

    // R5 R6 R7 R10: every enable and mode combination.
    for (int le = 0; le < 2; le++) begin
      for (int hd = 0; hd < 2; hd++) begin
        logic held;
        held = (le == 1) && (hd == 1);
        l2_en = 1'(le); ack_hold = 1'(hd);
        turnoff_rx = 1;
        user_ack = !held;  // ignored when automatic
        tick();
        turnoff_rx = 0; user_ack = 0;
        chk("R5", "l2_enter on turnoff", l2_enter, 1'(le));
        chk(held ? "R7" : "R6", "ack_tx with entry", ack_tx, !held);
        if (held) begin
          pwr_state = 2'b11; l1_en = 1;
          turnoff_rx = 1;
          tick();
          turnoff_rx = 0;
          chk("R5", "l2_enter one cycle", l2_enter, 1'b0);
          chk("R10", "l1 blocked while pending", l1_enter, 1'b0);
          tick();
          chk("R8", "turnoff while pending ignored", l2_enter, 1'b0);
          chk("R8", "no ack from turnoff while pending", ack_tx, 1'b0);
          chk("R10", "l1 still blocked", l1_enter, 1'b0);
          tick();
          chk("R7", "ack waits for user", ack_tx, 1'b0);
          pwr_state = 2'b00; l1_en = 0;
          user_ack = 1;
          tick();
          user_ack = 0;
          chk("R7", "ack_tx after user_ack", ack_tx, 1'b1);
        end
        tick();
        chk("R8", "single ack per turnoff", ack_tx, 1'b0);
        user_ack = 1;
        tick();
        user_ack = 0;
        chk("R9", "stray user_ack", ack_tx, 1'b0);
        tick();
        chk("R9", "stray user_ack later", ack_tx, 1'b0);
      end
    end

    // R1: entry resumes once the held acknowledge is given.
    l2_en = 1; ack_hold = 1; turnoff_rx = 1;
    tick();
    turnoff_rx = 0;
    pwr_state = 2'b01; l1_en = 1;
    tick();
    chk("R10", "blocked during handshake", l1_enter, 1'b0);
    user_ack = 1;
    tick();
    user_ack = 0;
    chk("R7", "ack on handshake", ack_tx, 1'b1);
    chk("R10", "still no entry on ack cycle", l1_enter, 1'b0);
    tick();
    chk("R1", "entry after pending clears", l1_enter, 1'b1);
    pwr_state = 2'b00; l1_en = 0; wake_req = 1;
    tick();
    wake_req = 0;
    chk("R3", "wake exit", l1_exit, 1'b1);

    // R11: reset mid-L1 clears state.
    pwr_state = 2'b10; l1_en = 1;
    tick();
    chk("R1", "entry before reset", l1_enter, 1'b1);
    pwr_state = 2'b00; l1_en = 0;
    rst_n = 0;
    tick();
    rst_n = 1;
    sys_exit_req = 1;
    tick();
    sys_exit_req = 0;
    chk("R11", "reset returned to L0", l1_exit, 1'b0);

    tick();
    finish_run();
  end
endmodule